// File: doc/BRIEF.md
# Push/Pop-Multiple Register Sequencer

This block executes a save-many or restore-many instruction by turning its register mask into a series of plain single-register memory operations. No microcode store is involved. The decode stage presents the instruction with three things: a bit mask with one bit per architectural register, a direction flag and the current stack pointer. On each step the sequencer picks one set bit and issues one load (for a pop) or one store (for a push) for that register at a stack address. It then clears that bit and moves the stack pointer by one word.

While work remains, the sequencer holds the instruction in decode through a stall output, so no younger instruction advances. A push walks the mask from the highest register down and decrements the pointer before each store. A pop walks from the lowest register up and increments the pointer after each load, so a pop undoes a push exactly. When the mask is empty, a one-cycle done pulse carries the final stack pointer for a single write-back. Back-pressure from memory freezes the current step.

Top module: `mrSequencer`

## Requirements
- R1: After reset, memReq, decodeStall and done are all low.
- R2: A start with k set mask bits produces exactly k accepted requests (memReq high with memReady high), one per set bit, each bit once.
- R3: A push (startIsPop=0) issues stores (memWrite=1) in descending register index order, and the address of each is the running stack pointer minus WORD_BYTES (pre-decrement), starting from startSp.
- R4: A pop (startIsPop=1) issues loads (memWrite=0) in ascending register index order, and the address of each is the running stack pointer before it is advanced by WORD_BYTES (post-increment), starting from startSp.
- R5: decodeStall is high in the start cycle of a non-empty mask and in every cycle in which a request is pending. It is low in the done cycle.
- R6: done is a single-cycle pulse in the cycle after the last request is accepted, with spOut = startSp - k*WORD_BYTES for a push or startSp + k*WORD_BYTES for a pop.
- R7: An all-zero mask issues no request and raises no stall. done follows in the next cycle with spOut equal to startSp.
- R8: While memReady is low, memReq stays high and memAddr, regIdx and memWrite hold their values until the request is accepted.
- R9: A pop of the same mask issued from the stack pointer a push returned restores the original stack pointer and visits the registers in the reverse of the push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Multi-register instruction present in decode (sampled while idle) |
| startIsPop | input | 1 | 1 = restore (pop), 0 = save (push) |
| startMask | input | NUM_REGS | One bit per register to transfer |
| startSp | input | ADDR_W | Stack pointer at instruction start |
| memReady | input | 1 | Memory side accepts the current request |
| memReq | output | 1 | Single-register load/store request valid |
| memWrite | output | 1 | 1 = store (push), 0 = load (pop) |
| memAddr | output | ADDR_W | Stack address of the current request |
| regIdx | output | IDX_W | Register index of the current request |
| decodeStall | output | 1 | Hold the instruction in decode |
| done | output | 1 | One-cycle completion pulse, stack-pointer write-back |
| spOut | output | ADDR_W | Final stack pointer, valid with done |

## Verification
A corrupted working mask shows at the ports within one step, as a repeated, skipped or out-of-order regIdx, or as the wrong number of accepted requests before done. A wrong stack-pointer register shows on memAddr at the very next request, because each address is a fixed word stride from the previous one. A final value that has drifted is exposed at the done pulse by spOut. A state machine that mishandles back-pressure moves memAddr or regIdx in a cycle where memReady was low. Such a fault appears in the cycle right after the refusal.

// File: rtl/mrSeqPkg.sv
package mrSeqPkg;
  typedef enum logic [1:0] {S_IDLE, S_STEP, S_DONE} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture instruction operands
    logic step;   // current request accepted: clear bit, move pointer
  } seqCtl_t;
endpackage

// File: rtl/mrSeqCtrl.sv
module mrSeqCtrl
  import mrSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  logic    startZero,
  input  logic    memReady,
  input  logic    lastStep,
  output seqCtl_t ctl,
  output logic    memReq,
  output logic    decodeStall,
  output logic    done
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl.load  = 1'b0;
    ctl.step  = 1'b0;
    case (state)
      S_IDLE: if (startValid) begin
        ctl.load  = 1'b1;
        stateNext = startZero ? S_DONE : S_STEP;
      end
      S_STEP: if (memReady) begin
        ctl.step = 1'b1;
        if (lastStep) stateNext = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign memReq      = (state == S_STEP);
  assign done        = (state == S_DONE);
  assign decodeStall = memReq | ((state == S_IDLE) & startValid & ~startZero);
endmodule

// File: rtl/mrSeqPath.sv
module mrSeqPath
  import mrSeqPkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 2,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic                startIsPop,
  input  logic [NUM_REGS-1:0] startMask,
  input  logic [ADDR_W-1:0]   startSp,
  output logic [IDX_W-1:0]    regIdx,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   spOut,
  output logic                lastStep
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

  logic [NUM_REGS-1:0] workMask;
  logic [ADDR_W-1:0]   sp;
  logic                isPop;
  logic [IDX_W-1:0]    hiIdx, loIdx;

  // highest and lowest set bit of the working mask
  always_comb begin
    hiIdx = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (workMask[i]) hiIdx = IDX_W'(i);
  end

  always_comb begin
    loIdx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--)
      if (workMask[i]) loIdx = IDX_W'(i);
  end

  assign regIdx   = isPop ? loIdx : hiIdx;
  assign memWrite = ~isPop;
  assign memAddr  = isPop ? sp : sp - STRIDE;
  assign spOut    = sp;
  assign lastStep = (workMask & (workMask - NUM_REGS'(1))) == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workMask <= '0;
      sp       <= '0;
      isPop    <= 1'b0;
    end else if (ctl.load) begin
      workMask <= startMask;
      sp       <= startSp;
      isPop    <= startIsPop;
    end else if (ctl.step) begin
      workMask <= workMask & ~(NUM_REGS'(1) << regIdx);
      sp       <= isPop ? sp + STRIDE : sp - STRIDE;
    end
  end
endmodule

// File: rtl/mrSequencer.sv
module mrSequencer
  import mrSeqPkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 2,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic                startIsPop,
  input  logic [NUM_REGS-1:0] startMask,
  input  logic [ADDR_W-1:0]   startSp,
  input  logic                memReady,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [IDX_W-1:0]    regIdx,
  output logic                decodeStall,
  output logic                done,
  output logic [ADDR_W-1:0]   spOut
);
  seqCtl_t ctl;
  logic    lastStep;

  mrSeqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .startZero(startMask == '0), .memReady(memReady), .lastStep(lastStep),
    .ctl(ctl), .memReq(memReq), .decodeStall(decodeStall), .done(done)
  );

  mrSeqPath #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startIsPop(startIsPop),
    .startMask(startMask), .startSp(startSp), .regIdx(regIdx),
    .memAddr(memAddr), .memWrite(memWrite), .spOut(spOut), .lastStep(lastStep)
  );
endmodule

// File: rtl/mrSeqChk.sv
module mrSeqChk #(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 2,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReady,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [IDX_W-1:0]  regIdx,
  input logic              decodeStall,
  input logic              done
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

  // R5
  req_stalls_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> decodeStall);

  // R5
  done_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !decodeStall && !memReq);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  hold_on_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(regIdx) && $stable(memWrite));

  // R3
  push_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && memWrite |=> !memReq || (regIdx < $past(regIdx) && memAddr == $past(memAddr) - STRIDE));

  // R4
  pop_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !memWrite |=> !memReq || (regIdx > $past(regIdx) && memAddr == $past(memAddr) + STRIDE));
endmodule

bind mrSequencer mrSeqChk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) i_chk (
  .clk(clk), .rstN(rstN), .memReady(memReady), .memReq(memReq), .memWrite(memWrite),
  .memAddr(memAddr), .regIdx(regIdx), .decodeStall(decodeStall), .done(done)
);

// File: tb/test_mrSequencer.sv
module test_mrSequencer;
  localparam int NR = 16;
  localparam int AW = 16;
  localparam int WB = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic          startIsPop = 1'b0;
  logic [NR-1:0] startMask = '0;
  logic [AW-1:0] startSp = '0;
  logic          memReady = 1'b1;
  logic          memReq, memWrite, decodeStall, done;
  logic [AW-1:0] memAddr, spOut;
  logic [3:0]    regIdx;

  int checks = 0;
  int errors = 0;
  int idxLog[NR];
  int idxCnt;
  logic [AW-1:0] lastSp;

  always #10 clk = ~clk;

  mrSequencer i_mrSequencer (.*);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Run one instruction; readyMode 0 = always ready, 1 = refuse every other cycle
  task automatic runOp(input bit pop, input logic [NR-1:0] mask, input logic [AW-1:0] sp, input int readyMode);
    logic [NR-1:0] rem = mask;
    logic [AW-1:0] expSp = sp;
    int   expCnt = 0, accCnt = 0, expIdx;
    bit   wasRefused = 0, finished = 0;
    logic [AW-1:0] holdAddr;
    int   holdIdx;
    for (int i = 0; i < NR; i++) if (mask[i]) expCnt++;
    idxCnt = 0;
    @(negedge clk);
    startValid = 1'b1; startIsPop = pop; startMask = mask; startSp = sp; memReady = 1'b1;
    #1;
    if (mask == '0) check(decodeStall == 1'b0, "R7", "stall on empty start", decodeStall, 0);
    else            check(decodeStall == 1'b1, "R5", "stall in start cycle", decodeStall, 1);
    for (int cyc = 0; cyc < 200 && !finished; cyc++) begin
      @(negedge clk);
      startValid = 1'b0;
      memReady = (readyMode == 1) ? cyc[0] : 1'b1;
      #1;
      if (wasRefused) begin
        check(memReq && memAddr == holdAddr && int'(regIdx) == holdIdx, "R8", "hold after refusal",
              int'(memAddr), int'(holdAddr));
        wasRefused = 0;
      end
      if (done) begin
        finished = 1;
        check(accCnt == expCnt, "R2", "accepted count", accCnt, expCnt);
        check(spOut == expSp, pop ? "R6" : "R6", "final sp", int'(spOut), int'(expSp));
        check(decodeStall == 1'b0, "R5", "stall low at done", decodeStall, 0);
        if (mask == '0) begin
          check(cyc == 0, "R7", "done latency on empty mask", cyc, 0);
          check(spOut == sp, "R7", "sp unchanged", int'(spOut), int'(sp));
        end
        lastSp = spOut;
      end else if (rem == '0) begin
        check(0, "R6", "done missing after last step", 0, 1);
      end else begin
        expIdx = 0;
        if (pop) begin for (int i = NR - 1; i >= 0; i--) if (rem[i]) expIdx = i; end
        else     begin for (int i = 0; i < NR; i++)      if (rem[i]) expIdx = i; end
        check(memReq == 1'b1, "R2", "request pending", memReq, 1);
        check(decodeStall == 1'b1, "R5", "stall while pending", decodeStall, 1);
        check(memWrite == !pop, pop ? "R4" : "R3", "load/store kind", memWrite, !pop);
        check(int'(regIdx) == expIdx, pop ? "R4" : "R3", "register order", int'(regIdx), expIdx);
        check(memAddr == (pop ? expSp : expSp - AW'(WB)), pop ? "R4" : "R3", "address",
              int'(memAddr), int'(pop ? expSp : expSp - AW'(WB)));
        if (memReady) begin
          accCnt++;
          idxLog[idxCnt] = expIdx; idxCnt++;
          rem[expIdx] = 1'b0;
          expSp = pop ? expSp + AW'(WB) : expSp - AW'(WB);
        end else begin
          wasRefused = 1; holdAddr = memAddr; holdIdx = int'(regIdx);
        end
      end
    end
    if (!finished) check(0, "R6", "operation never finished", 0, 1);
    @(negedge clk); #1;
    check(done == 1'b0, "R6", "done is one cycle", done, 0);
  endtask

  task automatic testReset();
    #1;
    check(memReq == 0 && decodeStall == 0 && done == 0, "R1", "outputs after reset",
          {memReq, decodeStall, done}, 0);
  endtask

  task automatic testPush();
    runOp(1'b0, 16'b1000_0100_0010_1001, 16'h1000, 0);   // R3 R6
  endtask

  task automatic testPop();
    runOp(1'b1, 16'b0101_0000_1100_0010, 16'h0800, 0);   // R4 R6
  endtask

  task automatic testEmpty();
    runOp(1'b0, 16'h0000, 16'h2222, 0);                  // R7
    runOp(1'b1, 16'h0000, 16'h3000, 0);                  // R7
  endtask

  task automatic testBackPressure();
    runOp(1'b0, 16'hF00F, 16'h4000, 1);                  // R8
    runOp(1'b1, 16'h0181, 16'h0010, 1);                  // R8
  endtask

  task automatic testFullAndWrap();
    runOp(1'b0, 16'hFFFF, 16'h0004, 0);                  // R2, address wraps below zero
    runOp(1'b1, 16'h8000, 16'hFFFE, 0);                  // R4 single bit, wraps past top
  endtask

  task automatic testRoundTrip();
    int pushOrder[NR];
    int n;
    logic [AW-1:0] base = 16'h5A00;
    runOp(1'b0, 16'b0011_1010_0110_0101, base, 0);
    n = idxCnt;
    for (int i = 0; i < n; i++) pushOrder[i] = idxLog[i];
    runOp(1'b1, 16'b0011_1010_0110_0101, lastSp, 1);
    check(lastSp == base, "R9", "sp restored", int'(lastSp), int'(base));
    check(idxCnt == n, "R9", "pop count", idxCnt, n);
    for (int i = 0; i < n; i++)
      check(idxLog[i] == pushOrder[n - 1 - i], "R9", "reverse order", idxLog[i], pushOrder[n - 1 - i]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPush();
    testPop();
    testEmpty();
    testBackPressure();
    testFullAndWrap();
    testRoundTrip();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule